// File: doc/BRIEF.md
# Big/Little Interval Mode Arbiter

This block picks the execution mode of an asymmetric processor that keeps exactly one of its two cores running at a time. Work is split into intervals of a fixed instruction count. Before each interval, the block receives two cycle counts for that interval: one for the big core and one for the little core. The counts may be measured or predicted. The block then decides which core runs the interval.

A mode change is paid for by adding a programmable switching cost, in cycles, to the core that is switched to. A penalty ratio in unsigned Q2.8 format sets how much slowdown is tolerated. The two switching directions use different inequalities. Leaving the big core requires the cost-burdened little core to stay within the penalty. Returning to the big core requires the cost-burdened big core to beat the penalised little core strictly. As a result, a large switching cost keeps the processor on the little core once it is there.

Decisions are only compared in cycles, so the block needs no divider. Four saturating counters support energy accounting:
- instructions run in little mode,
- number of switches,
- cycles spent switching,
- total charged cycles.

Top module: `modeArbiter`

## Requirements
- R1: After reset, the mode is big (`modeLittle`=0), `switchStrobe` and `outValid` are 0, and all four counters read zero.
- R2: `inReady` is always 1. Each cycle with `inValid`=1 yields exactly one decision beat. `outValid`=1 and the new mode and counters appear one clock later.
- R3: In big mode the interval moves to little (`modeLittle`=1) when (littleCycles + cost)·256 ≤ bigCycles·P. Otherwise it stays big.
- R4: In little mode the interval moves back to big when (bigCycles + cost)·P < littleCycles·256 (strict). Otherwise it stays little.
- R5: A penalty value below 256 (1.00 in Q2.8) is treated as exactly 256.
- R6: `switchStrobe` is 1 on a decision beat if and only if the mode on that beat differs from the mode before it.
- R7: Each switch adds 1 to `switchCount` and adds the switching cost to `switchCycleCount`.
- R8: `chargedCycleCount` adds, on each decision beat, the cycle count of the chosen core, plus the switching cost when the beat switches.
- R9: `littleInstrCount` adds the interval length on every decision beat whose chosen mode is little.
- R10: Every counter saturates at all ones instead of wrapping.
- R11: In a cycle without an accepted interval, the mode and all counters hold and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Interval cycle counts are valid |
| inReady | output | 1 | Always ready to take an interval |
| bigCycles | input | CYC_W | Cycles the big core needs for the interval |
| littleCycles | input | CYC_W | Cycles the little core needs for the interval |
| cfgSwitchCost | input | COST_W | Cycles charged per mode change |
| cfgPenalty | input | PEN_W | Tolerated slowdown, unsigned Q2.8 |
| cfgIntervalLen | input | LEN_W | Instructions per interval |
| outValid | output | 1 | Decision beat |
| modeLittle | output | 1 | 1 = little core chosen, 0 = big core |
| switchStrobe | output | 1 | Mode changed on this beat |
| littleInstrCount | output | CNT_W | Instructions run in little mode |
| switchCount | output | CNT_W | Number of mode changes |
| switchCycleCount | output | CNT_W | Cycles spent switching |
| chargedCycleCount | output | CNT_W | Total charged cycles |

## Verification
The assertions check the following on every cycle:
- the one-clock link between acceptance and the decision beat,
- that `switchStrobe` and a real mode change coincide,
- that each switch adds exactly one to the switch count and the configured cost to the switch-cycle count,
- that nothing moves on idle cycles.

The choice of direction cannot be shown by any per-cycle property; only the bench scenarios can show it. These scenarios cover:
- the rejected big-to-little case with a 500-cycle cost and a 1.25 penalty,
- a return to big refused under a 10000-cycle cost,
- equal cycle counts under a 1.00 penalty, where the non-strict and strict inequalities give different results,
- a penalty below 1.00 being clamped,
- counter saturation after hundreds of maximal intervals.

// File: rtl/modeArbPkg.sv
package modeArbPkg;
  // strobes from control to datapath, valid for the accepting cycle
  typedef struct packed {
    logic load;
    logic doSwitch;
    logic nextLittle;
  } arbStrobe_t;
endpackage

// File: rtl/modeArbDatapath.sv
module modeArbDatapath
  import modeArbPkg::*;
#(
  parameter int CYC_W  = 24,
  parameter int COST_W = 16,
  parameter int PEN_W  = 10,
  parameter int FRAC_W = 8,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic [CYC_W-1:0]  bigCycles,
  input  logic [CYC_W-1:0]  littleCycles,
  input  logic [COST_W-1:0] cfgSwitchCost,
  input  logic [PEN_W-1:0]  cfgPenalty,
  input  logic [LEN_W-1:0]  cfgIntervalLen,
  output logic              toLittleOk,
  output logic              toBigOk,
  output logic [CNT_W-1:0]  littleInstrCount,
  output logic [CNT_W-1:0]  switchCount,
  output logic [CNT_W-1:0]  switchCycleCount,
  output logic [CNT_W-1:0]  chargedCycleCount
);
  localparam int SUM_W  = ((CYC_W > COST_W) ? CYC_W : COST_W) + 1;
  localparam int PROD_W = SUM_W + PEN_W + FRAC_W + 1;
  localparam int NCNT   = 4;
  localparam logic [PEN_W-1:0] UNITY = PEN_W'(1 << FRAC_W);

  logic [PEN_W-1:0]  penEff;
  logic [SUM_W-1:0]  littleBurdened, bigBurdened;
  logic [PROD_W-1:0] lhsToLittle, rhsToLittle, lhsToBig, rhsToBig;

  always_comb begin
    penEff         = (cfgPenalty < UNITY) ? UNITY : cfgPenalty;
    littleBurdened = SUM_W'(littleCycles) + SUM_W'(cfgSwitchCost);
    bigBurdened    = SUM_W'(bigCycles) + SUM_W'(cfgSwitchCost);
    lhsToLittle    = PROD_W'(littleBurdened) << FRAC_W;
    rhsToLittle    = PROD_W'(bigCycles) * PROD_W'(penEff);
    lhsToBig       = PROD_W'(bigBurdened) * PROD_W'(penEff);
    rhsToBig       = PROD_W'(littleCycles) << FRAC_W;
    toLittleOk     = lhsToLittle <= rhsToLittle;
    toBigOk        = lhsToBig < rhsToBig;
  end

  logic [CNT_W-1:0] incr [NCNT];
  logic [CNT_W-1:0] cnt  [NCNT];

  always_comb begin
    incr[0] = strobe.nextLittle ? CNT_W'(cfgIntervalLen) : '0;
    incr[1] = strobe.doSwitch ? CNT_W'(1) : '0;
    incr[2] = strobe.doSwitch ? CNT_W'(cfgSwitchCost) : '0;
    incr[3] = (strobe.nextLittle ? CNT_W'(littleCycles) : CNT_W'(bigCycles))
            + (strobe.doSwitch ? CNT_W'(cfgSwitchCost) : '0);
  end

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    logic [CNT_W:0] wide;
    assign wide = {1'b0, cnt[gi]} + {1'b0, incr[gi]};
    always_ff @(posedge clk) begin
      if (!rstN)            cnt[gi] <= '0;
      else if (strobe.load) cnt[gi] <= wide[CNT_W] ? '1 : wide[CNT_W-1:0];
    end
  end

  assign littleInstrCount  = cnt[0];
  assign switchCount       = cnt[1];
  assign switchCycleCount  = cnt[2];
  assign chargedCycleCount = cnt[3];
endmodule

// File: rtl/modeArbCtrl.sv
module modeArbCtrl
  import modeArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       toLittleOk,
  input  logic       toBigOk,
  output arbStrobe_t strobe,
  output logic       modeLittle,
  output logic       switchStrobe,
  output logic       outValid
);
  always_comb begin
    strobe.load       = inValid;
    strobe.nextLittle = modeLittle ? !toBigOk : toLittleOk;
    strobe.doSwitch   = inValid && (strobe.nextLittle != modeLittle);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeLittle   <= 1'b0;
      switchStrobe <= 1'b0;
      outValid     <= 1'b0;
    end else begin
      outValid     <= strobe.load;
      switchStrobe <= strobe.doSwitch;
      if (strobe.load) modeLittle <= strobe.nextLittle;
    end
  end
endmodule

// File: rtl/modeArbiter.sv
module modeArbiter
  import modeArbPkg::*;
#(
  parameter int CYC_W  = 24,
  parameter int COST_W = 16,
  parameter int PEN_W  = 10,
  parameter int FRAC_W = 8,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CYC_W-1:0]  bigCycles,
  input  logic [CYC_W-1:0]  littleCycles,
  input  logic [COST_W-1:0] cfgSwitchCost,
  input  logic [PEN_W-1:0]  cfgPenalty,
  input  logic [LEN_W-1:0]  cfgIntervalLen,
  output logic              outValid,
  output logic              modeLittle,
  output logic              switchStrobe,
  output logic [CNT_W-1:0]  littleInstrCount,
  output logic [CNT_W-1:0]  switchCount,
  output logic [CNT_W-1:0]  switchCycleCount,
  output logic [CNT_W-1:0]  chargedCycleCount
);
  arbStrobe_t strobe;
  logic       toLittleOk, toBigOk;

  assign inReady = 1'b1;

  modeArbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .toLittleOk(toLittleOk), .toBigOk(toBigOk), .strobe(strobe),
    .modeLittle(modeLittle), .switchStrobe(switchStrobe), .outValid(outValid)
  );

  modeArbDatapath #(
    .CYC_W(CYC_W), .COST_W(COST_W), .PEN_W(PEN_W),
    .FRAC_W(FRAC_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bigCycles(bigCycles), .littleCycles(littleCycles),
    .cfgSwitchCost(cfgSwitchCost), .cfgPenalty(cfgPenalty),
    .cfgIntervalLen(cfgIntervalLen),
    .toLittleOk(toLittleOk), .toBigOk(toBigOk),
    .littleInstrCount(littleInstrCount), .switchCount(switchCount),
    .switchCycleCount(switchCycleCount), .chargedCycleCount(chargedCycleCount)
  );
endmodule

// File: rtl/modeArbChecker.sv
module modeArbChecker #(
  parameter int COST_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [COST_W-1:0] cfgSwitchCost,
  input logic              outValid,
  input logic              modeLittle,
  input logic              switchStrobe,
  input logic [CNT_W-1:0]  switchCount,
  input logic [CNT_W-1:0]  switchCycleCount
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  a_r2_one_beat_later: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> (outValid == $past(inValid && inReady)));

  a_r6_change_has_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (seen && (modeLittle != $past(modeLittle))) |-> switchStrobe);

  a_r6_strobe_has_change: assert property (@(posedge clk) disable iff (!rstN)
    (seen && switchStrobe) |-> (modeLittle != $past(modeLittle)));

  a_r7_switch_counted: assert property (@(posedge clk) disable iff (!rstN)
    (seen && switchStrobe && ($past(switchCount) != '1))
      |-> (switchCount == $past(switchCount) + 1'b1));

  a_r7_cost_accumulated: assert property (@(posedge clk) disable iff (!rstN)
    (seen && switchStrobe &&
     (({1'b0, $past(switchCycleCount)} + (CNT_W+1)'($past(cfgSwitchCost))) <= {1'b0, {CNT_W{1'b1}}}))
      |-> (switchCycleCount == $past(switchCycleCount) + CNT_W'($past(cfgSwitchCost))));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !outValid) |-> ($stable(modeLittle) && $stable(switchCount) && $stable(switchCycleCount)));
endmodule

bind modeArbiter modeArbChecker #(.COST_W(COST_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .cfgSwitchCost(cfgSwitchCost), .outValid(outValid), .modeLittle(modeLittle),
  .switchStrobe(switchStrobe), .switchCount(switchCount),
  .switchCycleCount(switchCycleCount)
);

// File: tb/tb_modeArbiter.sv
module tb_modeArbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [23:0] bigCycles = '0, littleCycles = '0;
  logic [15:0] cfgSwitchCost = '0;
  logic [9:0]  cfgPenalty = 10'd294;
  logic [15:0] cfgIntervalLen = 16'd1000;
  logic        outValid, modeLittle, switchStrobe;
  logic [31:0] littleInstrCount, switchCount, switchCycleCount, chargedCycleCount;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit     mMode = 0, mStrobe = 0, mValid = 0;
  longint mLittle = 0, mSw = 0, mSwCyc = 0, mCharged = 0;
  localparam longint SAT = 64'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  modeArbiter dut (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint satAdd(longint a, longint b);
    return (a + b > SAT) ? SAT : a + b;
  endfunction

  task automatic compareAll();
    chk("R2 outValid", outValid, mValid);
    chk("R3 R4 modeLittle", modeLittle, mMode);
    chk("R6 switchStrobe", switchStrobe, mStrobe);
    chk("R7 switchCount", switchCount, mSw);
    chk("R7 switchCycleCount", switchCycleCount, mSwCyc);
    chk("R8 chargedCycleCount", chargedCycleCount, mCharged);
    chk("R9 littleInstrCount", littleInstrCount, mLittle);
  endtask

  // one clock: drive at negedge, update reference at posedge, compare at next negedge
  task automatic step(bit v, int cb, int cl);
    longint p, cost;
    bit nxt;
    inValid = v; bigCycles = 24'(cb); littleCycles = 24'(cl);
    @(posedge clk);
    p = (cfgPenalty < 256) ? 256 : cfgPenalty;
    cost = cfgSwitchCost;
    mValid = v; mStrobe = 0;
    if (v) begin
      if (!mMode) nxt = ((cl + cost) * 256 <= longint'(cb) * p);
      else        nxt = !((cb + cost) * p < longint'(cl) * 256);
      mStrobe = (nxt != mMode);
      mMode = nxt;
      if (mStrobe) begin
        mSw = satAdd(mSw, 1); mSwCyc = satAdd(mSwCyc, cost);
      end
      mCharged = satAdd(mCharged, (nxt ? cl : cb) + (mStrobe ? cost : 0));
      if (nxt) mLittle = satAdd(mLittle, cfgIntervalLen);
    end
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", modeLittle, 0);
    chk("R1 strobe", switchStrobe, 0);
    chk("R1 valid", outValid, 0);
    chk("R1 counters", longint'(switchCount) + chargedCycleCount + switchCycleCount + littleInstrCount, 0);
    chk("R2 inReady", inReady, 1);
    rstN = 1;
    @(negedge clk);

    // R3 worked example: IPC 1.0 vs 0.8, cost 500, penalty 1.25 -> stays big
    cfgSwitchCost = 500; cfgPenalty = 320;
    step(1, 1000, 1250);
    chk("R3 stays big", modeLittle, 0);
    // R11 idle cycles
    step(0, 7, 7); step(0, 9, 1);
    // R3 cheap switch to little, penalty 1.15
    cfgSwitchCost = 30; cfgPenalty = 294;
    step(1, 1000, 1100);
    chk("R3 goes little", modeLittle, 1);
    // R4 reversal rejected by high cost
    cfgSwitchCost = 10000;
    step(1, 500, 1000);
    chk("R4 stays little", modeLittle, 1);
    // R4 reversal accepted at low cost
    cfgSwitchCost = 30;
    step(1, 500, 1000);
    chk("R4 back to big", modeLittle, 0);
    // R3 R4 equal IPC, penalty 1.00, cost 0: leave big, refuse return
    cfgSwitchCost = 0; cfgPenalty = 256;
    step(1, 1000, 1000);
    chk("R3 equal goes little", modeLittle, 1);
    step(1, 1000, 1000);
    chk("R4 equal stays little", modeLittle, 1);
    step(1, 999, 1000);
    chk("R4 strictly faster returns", modeLittle, 0);
    // R5 penalty below 1.00 clamped: equal cycles still move to little
    cfgPenalty = 100;
    step(1, 1000, 1000);
    chk("R5 clamp", modeLittle, 1);
    cfgPenalty = 294;
    for (int i = 0; i < 12; i++) step(1, 400 + 37 * i, 300 + 91 * (i % 5));
    // R10 saturation: big mode, maximal cycles, slow little
    cfgSwitchCost = 30; cfgPenalty = 256;
    step(1, 1, 16000000);
    for (int i = 0; i < 300; i++) step(1, 24'hFFFFFF, 24'hFFFFFF - 1);
    chk("R10 charged saturates", chargedCycleCount, SAT);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule